// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Unit

This unit pairs two eight-line interrupt controller cores. The master core serves raw request lines 0 to 7. The slave core serves raw lines 8 to 15. The slave's interrupt output takes the place of master line 2. Each core turns its raw inputs into pending requests, either on rising edges or on levels, as its edge/level select register chooses. A combinational resolver picks the winning request in each core, using the current rotation offset and the lines in service.

When the processor pulses the acknowledge strobe, the unit drives an 8-bit vector in that same cycle. The vector is the owning core's 5-bit base in bits 7..3 and the line number in bits 2..0. At the following clock edge the unit updates the request, in-service and rotation state of the cores involved.

The following arrive as plain inputs: the bases, the per-core request masks, automatic end-of-interrupt, rotate-on-automatic-end-of-interrupt, nested handling of the cascade line, and a non-specific end-of-interrupt strobe. The edge/level select registers are written through a small strobe-and-data port.

Top module: `cascade_intack`

## Requirements
- R1: After reset, every request, last-level, in-service and rotation register is zero, and both select registers hold all-edge (0). int_o is low, and vector_o reads {mst_base_i, 3'd7}.
- R2: For a line whose select bit is 1 (level), the pending bit at the next clock equals the raw input. An acknowledge never clears it.
- R3: For a line whose select bit is 0 (edge), the pending bit is set only when the input is 1 and the stored last level is 0. A held or falling input leaves the pending bit alone and only updates the last level.
- R4: A select write (elsel_we_i bit 0 = master, bit 1 = slave) stores elsel_wdata_i ANDed with that core's level-capable mask, which defaults to 8'hF8 for the master and 8'hDE for the slave. The other lines stay edge.
- R5: A core's winner is its pending, unmasked line (mask bit 1 = blocked) that comes first in the order rot, rot+1, ... mod 8. It counts only if it comes strictly earlier than the first in-service line in that order.
- R6: On acknowledge in normal mode, the winning line's in-service bit is set and, for an edge line, its pending bit is cleared. The vector is {base, line}.
- R7: With automatic end-of-interrupt on (auto_eoi_i bit per core), the in-service bit is not set. If rotation is also on, the rotation offset becomes (line+1) mod 8.
- R8: When the master winner is line 2 and the slave has a winner, both are acknowledged and vector_o is {slv_base_i, slave line}.
- R9: When the master winner is line 2 and the slave has no winner, only master line 2 is acknowledged and vector_o is {slv_base_i, 3'd7}.
- R10: When the master has no winner, vector_o is {mst_base_i, 3'd7} and an acknowledge changes no state.
- R11: Raw input irq_i[2] has no effect. Master line 2 samples the slave's interrupt output through the edge capture, one clock later.
- R12: With nested_i high, the master's in-service bit 2 is left out of the master's current-priority check.
- R13: eoi_i (bit per core) clears the first in-service bit in that core's rotation order. An end-of-interrupt and an acknowledge in the same cycle both take effect. A new edge on the line being acknowledged in the same cycle leaves that line pending.
- R14: int_o is high exactly when the master core has a winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 16 | Raw request lines, 7..0 master, 15..8 slave |
| elsel_we_i | input | 2 | Select register write strobe per core |
| elsel_wdata_i | input | 8 | Select register write data |
| mst_mask_i | input | 8 | Master request mask, 1 blocks the line |
| slv_mask_i | input | 8 | Slave request mask, 1 blocks the line |
| mst_base_i | input | 5 | Master vector base, bits 7..3 |
| slv_base_i | input | 5 | Slave vector base, bits 7..3 |
| auto_eoi_i | input | 2 | Automatic end-of-interrupt per core |
| rot_aeoi_i | input | 2 | Rotate on automatic end-of-interrupt per core |
| nested_i | input | 1 | Ignore master in-service line 2 for priority |
| eoi_i | input | 2 | Non-specific end-of-interrupt strobe per core |
| ack_i | input | 1 | Acknowledge strobe |
| int_o | output | 1 | Master interrupt request |
| vector_o | output | 8 | Vector, valid in the acknowledge cycle |

## Verification
Two things can meet on the same edge. An acknowledge clears an edge line's pending bit while a fresh rising edge on that same line sets it, and an end-of-interrupt removes an in-service bit while the acknowledge adds one. The directed phase forces both collisions on purpose. A long random phase then drives acknowledge, end-of-interrupt and raw toggles at rates high enough to make them coincide often. A behavioural model in the bench applies the clear before the capture and the end-of-interrupt before the new in-service bit. Every vector and int_o value is compared with it on every clock, so a wrong resolution order shows up as a miscompare within a few cycles.

// File: rtl/cim_pkg.sv
package cim_pkg;
  localparam int unsigned LINES = 8;
  localparam int unsigned LW    = $clog2(LINES);

  typedef logic [LINES-1:0] line_vec_t;
  typedef logic [LW-1:0]    line_idx_t;
  typedef logic [LW:0]      prio_t;

  // rank of the first set bit counting from rot; LINES when empty
  function automatic prio_t first_prio(line_vec_t v, line_idx_t rot);
    prio_t     p;
    line_idx_t idx;
    p = prio_t'(LINES);
    for (int k = LINES - 1; k >= 0; k--) begin
      idx = line_idx_t'(k) + rot;
      if (v[idx]) p = prio_t'(k);
    end
    return p;
  endfunction
endpackage

// File: rtl/cim_req_capture.sv
module cim_req_capture
  import cim_pkg::*;
#(
  parameter line_vec_t LVL_OK = '1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_vec_t raw_i,
  input  logic      elsel_we_i,
  input  line_vec_t elsel_wdata_i,
  input  line_vec_t ack_clr_i,
  output line_vec_t irr_o
);
  line_vec_t elsel_q, last_q, irr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         elsel_q <= '0;
    else if (elsel_we_i) elsel_q <= elsel_wdata_i & LVL_OK;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        last_q[i] <= 1'b0;
        irr_q[i]  <= 1'b0;
      end else begin
        last_q[i] <= raw_i[i];
        if (elsel_q[i]) irr_q[i] <= raw_i[i];
        else            irr_q[i] <= (irr_q[i] & ~ack_clr_i[i]) | (raw_i[i] & ~last_q[i]);
      end
    end

    // R2
    level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      elsel_q[i] |=> irr_q[i] == $past(raw_i[i]));

    // R3
    edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!elsel_q[i] && last_q[i] && !ack_clr_i[i]) |=> irr_q[i] == $past(irr_q[i]));
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/cim_prio_resolve.sv
module cim_prio_resolve
  import cim_pkg::*;
(
  input  line_vec_t irr_i,
  input  line_vec_t mask_i,
  input  line_vec_t isr_i,
  input  line_vec_t isr_ignore_i,
  input  line_idx_t rot_i,
  output logic      win_vld_o,
  output line_idx_t win_line_o,
  output logic      top_isr_vld_o,
  output line_idx_t top_isr_line_o
);
  prio_t req_p, cur_p, isr_p;

  always_comb begin
    req_p          = first_prio(irr_i & ~mask_i, rot_i);
    cur_p          = first_prio(isr_i & ~isr_ignore_i, rot_i);
    isr_p          = first_prio(isr_i, rot_i);
    win_vld_o      = req_p < cur_p;
    win_line_o     = req_p[LW-1:0] + rot_i;
    top_isr_vld_o  = !isr_p[LW];
    top_isr_line_o = isr_p[LW-1:0] + rot_i;
  end
endmodule

// File: rtl/cim_core.sv
module cim_core
  import cim_pkg::*;
#(
  parameter line_vec_t LVL_OK = '1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_vec_t raw_i,
  input  logic      elsel_we_i,
  input  line_vec_t elsel_wdata_i,
  input  line_vec_t mask_i,
  input  line_vec_t isr_ignore_i,
  input  logic      auto_eoi_i,
  input  logic      rot_aeoi_i,
  input  logic      eoi_i,
  input  logic      ack_i,
  output logic      win_vld_o,
  output line_idx_t win_line_o
);
  line_vec_t isr_q, irr, ack_vec, eoi_vec;
  line_idx_t rot_q, top_line;
  logic      top_vld;

  assign ack_vec = ack_i ? line_vec_t'(1) << win_line_o : '0;
  assign eoi_vec = (eoi_i && top_vld) ? line_vec_t'(1) << top_line : '0;

  cim_req_capture #(.LVL_OK(LVL_OK)) u_cap (
    .clk_i, .rst_ni, .raw_i, .elsel_we_i, .elsel_wdata_i,
    .ack_clr_i (ack_vec),
    .irr_o     (irr)
  );

  cim_prio_resolve u_res (
    .irr_i          (irr),
    .mask_i,
    .isr_i          (isr_q),
    .isr_ignore_i,
    .rot_i          (rot_q),
    .win_vld_o,
    .win_line_o,
    .top_isr_vld_o  (top_vld),
    .top_isr_line_o (top_line)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
      rot_q <= '0;
    end else begin
      isr_q <= (isr_q & ~eoi_vec) | (auto_eoi_i ? '0 : ack_vec);
      if (ack_i && auto_eoi_i && rot_aeoi_i) rot_q <= win_line_o + 1'b1;
    end
  end

  // R9
  ack_needs_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> win_vld_o);

  // R6
  ack_sets_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !auto_eoi_i) |=> isr_q[$past(win_line_o)]);

  // R7
  aeoi_keeps_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && auto_eoi_i && !eoi_i) |=> $stable(isr_q));

  // R7
  aeoi_rotate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && auto_eoi_i && rot_aeoi_i) |=> rot_q == line_idx_t'($past(win_line_o) + 1'b1));

  // R5
  win_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld_o |-> !mask_i[win_line_o]);
endmodule

// File: rtl/cascade_intack.sv
module cascade_intack
  import cim_pkg::*;
#(
  parameter line_vec_t MST_LVL_OK = 8'hF8,
  parameter line_vec_t SLV_LVL_OK = 8'hDE
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] irq_i,
  input  logic [1:0]  elsel_we_i,
  input  logic [7:0]  elsel_wdata_i,
  input  logic [7:0]  mst_mask_i,
  input  logic [7:0]  slv_mask_i,
  input  logic [4:0]  mst_base_i,
  input  logic [4:0]  slv_base_i,
  input  logic [1:0]  auto_eoi_i,
  input  logic [1:0]  rot_aeoi_i,
  input  logic        nested_i,
  input  logic [1:0]  eoi_i,
  input  logic        ack_i,
  output logic        int_o,
  output logic [7:0]  vector_o
);
  localparam line_idx_t CASC_LINE = line_idx_t'(2);
  localparam line_idx_t SPUR_LINE = line_idx_t'(LINES - 1);

  line_vec_t m_raw, m_ignore;
  logic      m_vld, s_vld, m_ack, s_ack, m_is_casc;
  line_idx_t m_line, s_line;

  always_comb begin
    m_raw            = irq_i[7:0];
    m_raw[CASC_LINE] = s_vld;    // R11: raw line replaced by the slave output
  end

  assign m_ignore  = nested_i ? line_vec_t'(1) << CASC_LINE : '0;
  assign m_is_casc = m_line == CASC_LINE;
  assign m_ack     = ack_i && m_vld;
  assign s_ack     = m_ack && m_is_casc && s_vld;

  cim_core #(.LVL_OK(MST_LVL_OK)) u_mst (
    .clk_i, .rst_ni,
    .raw_i         (m_raw),
    .elsel_we_i    (elsel_we_i[0]),
    .elsel_wdata_i,
    .mask_i        (mst_mask_i),
    .isr_ignore_i  (m_ignore),
    .auto_eoi_i    (auto_eoi_i[0]),
    .rot_aeoi_i    (rot_aeoi_i[0]),
    .eoi_i         (eoi_i[0]),
    .ack_i         (m_ack),
    .win_vld_o     (m_vld),
    .win_line_o    (m_line)
  );

  cim_core #(.LVL_OK(SLV_LVL_OK)) u_slv (
    .clk_i, .rst_ni,
    .raw_i         (irq_i[15:8]),
    .elsel_we_i    (elsel_we_i[1]),
    .elsel_wdata_i,
    .mask_i        (slv_mask_i),
    .isr_ignore_i  ('0),
    .auto_eoi_i    (auto_eoi_i[1]),
    .rot_aeoi_i    (rot_aeoi_i[1]),
    .eoi_i         (eoi_i[1]),
    .ack_i         (s_ack),
    .win_vld_o     (s_vld),
    .win_line_o    (s_line)
  );

  always_comb begin
    if (!m_vld)         vector_o = {mst_base_i, SPUR_LINE};
    else if (!m_is_casc) vector_o = {mst_base_i, m_line};
    else if (s_vld)     vector_o = {slv_base_i, s_line};
    else                vector_o = {slv_base_i, SPUR_LINE};
  end

  assign int_o = m_vld;

  // R10
  mst_spur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !int_o) |-> vector_o == {mst_base_i, 3'd7});

  // R9
  slv_spur_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && m_vld && m_is_casc && !s_vld) |-> vector_o[2:0] == 3'd7);
endmodule

// File: tb/cascade_intack_tb.sv
module cascade_intack_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic [1:0]  we = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  mmask = '0, smask = '0;
  logic [4:0]  mbase = 5'h01, sbase = 5'h0E;
  logic [1:0]  aeoi = '0, roten = '0, eoi = '0;
  logic        nested = 1'b0, ack = 1'b0;
  logic        int_w;
  logic [7:0]  vec_w;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  bit [7:0] m_irr[2], m_last[2], m_isr[2], m_el[2];
  int       m_rot[2];
  bit [7:0] lvl_ok[2] = '{8'hF8, 8'hDE};

  always #10 clk = ~clk;

  cascade_intack u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .elsel_we_i(we), .elsel_wdata_i(wdata),
    .mst_mask_i(mmask), .slv_mask_i(smask), .mst_base_i(mbase), .slv_base_i(sbase),
    .auto_eoi_i(aeoi), .rot_aeoi_i(roten), .nested_i(nested), .eoi_i(eoi), .ack_i(ack),
    .int_o(int_w), .vector_o(vec_w)
  );

  function automatic int pr(bit [7:0] v, int r);
    for (int k = 0; k < 8; k++) if (v[(k + r) % 8]) return k;
    return 8;
  endfunction

  function automatic int winner(int c);
    bit [7:0] req, iv;
    int rp, cp;
    req = m_irr[c] & ~(c == 0 ? mmask : smask);
    iv  = m_isr[c];
    if (c == 0 && nested) iv[2] = 1'b0;
    rp = pr(req, m_rot[c]);
    cp = pr(iv, m_rot[c]);
    if (rp < cp) return (rp + m_rot[c]) % 8;
    return -1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    int sw, mw, ev, a[2], eol, ln;
    bit [7:0] raw[2];
    string tag;
    #1;
    sw = winner(1);
    mw = winner(0);
    if (mw < 0)       ev = {mbase, 3'd7};
    else if (mw != 2) ev = {mbase, 3'(mw)};
    else if (sw >= 0) ev = {sbase, 3'(sw)};
    else              ev = {sbase, 3'd7};
    tag = cur_req;
    if (ack && mw < 0) tag = "R10";
    else if (ack && mw == 2 && sw < 0) tag = "R9";
    else if (ack && mw == 2) tag = "R8";
    check(vec_w == 8'(ev), tag, vec_w, ev);
    check(int_w == (mw >= 0), "R14", int_w, mw >= 0);
    // model update for the coming edge
    a[0] = (ack && mw >= 0) ? mw : -1;
    a[1] = (ack && mw == 2 && sw >= 0) ? sw : -1;
    raw[0] = irq[7:0];
    raw[0][2] = (sw >= 0);
    raw[1] = irq[15:8];
    for (int c = 0; c < 2; c++) begin
      eol = pr(m_isr[c], m_rot[c]);
      for (int i = 0; i < 8; i++) begin
        if (m_el[c][i]) m_irr[c][i] = raw[c][i];
        else begin
          if (a[c] == i) m_irr[c][i] = 1'b0;
          if (raw[c][i] && !m_last[c][i]) m_irr[c][i] = 1'b1;
        end
        m_last[c][i] = raw[c][i];
      end
      if (eoi[c] && eol < 8) begin
        ln = (eol + m_rot[c]) % 8;
        m_isr[c][ln] = 1'b0;
      end
      if (a[c] >= 0 && !aeoi[c]) m_isr[c][a[c]] = 1'b1;
      if (a[c] >= 0 && aeoi[c] && roten[c]) m_rot[c] = (a[c] + 1) % 8;
      if (we[c]) m_el[c] = wdata & lvl_ok[c];
    end
    @(negedge clk);
    ack = 0; eoi = '0; we = '0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_irr[c] = 0; m_last[c] = 0; m_isr[c] = 0; m_el[c] = 0; m_rot[c] = 0;
    end
    repeat (3) @(negedge clk);
    #1;
    check(int_w == 1'b0, "R1", int_w, 0);
    check(vec_w == {mbase, 3'd7}, "R1", vec_w, {mbase, 3'd7});
    rst_n = 1'b1;
    @(negedge clk);
    ticks(2);

    cur_req = "R3";                       // edge capture, hold, re-arm
    irq[0] = 1; ticks(2); ack = 1; tick(); ticks(3);
    irq[0] = 0; tick(); irq[0] = 1; ticks(2); eoi[0] = 1; tick(); ticks(2);
    cur_req = "R6";
    ack = 1; tick(); ticks(2); eoi[0] = 1; tick();
    irq[0] = 0; ticks(2);

    cur_req = "R4";                       // only level-capable bits stick
    we[0] = 1; wdata = 8'hFF; tick();
    irq[1] = 1; ticks(2); ack = 1; tick(); eoi[0] = 1; tick(); ticks(3); irq[1] = 0; tick();
    cur_req = "R2";
    irq[5] = 1; ticks(2); ack = 1; tick(); eoi[0] = 1; tick(); ticks(2);
    ack = 1; tick(); eoi[0] = 1; tick(); irq[5] = 0; ticks(3);

    cur_req = "R11";
    irq[2] = 1; ticks(4); irq[2] = 0; ticks(2);

    cur_req = "R8";
    irq[12] = 1; ticks(3); ack = 1; tick(); ticks(2);
    cur_req = "R12";
    nested = 1; irq[14] = 1; ticks(3); ack = 1; tick(); ticks(2);
    eoi = 2'b11; tick(); eoi = 2'b11; tick(); eoi = 2'b11; tick(); nested = 0;
    irq[12] = 0; irq[14] = 0; ticks(3);

    cur_req = "R9";
    we[1] = 1; wdata = 8'h08; tick();
    irq[11] = 1; ticks(3); irq[11] = 0; tick(); ack = 1; tick(); ticks(2);
    eoi[0] = 1; tick(); ticks(2);

    cur_req = "R10";
    ack = 1; tick(); ticks(1);

    cur_req = "R7";
    aeoi = 2'b01; roten = 2'b01;
    irq[6] = 1; ticks(2); ack = 1; tick(); irq[4] = 1; irq[7] = 1; ticks(2);
    ack = 1; tick(); ack = 1; tick(); ticks(2);
    aeoi = 0; roten = 0; irq[6] = 0; irq[4] = 0; irq[7] = 0; ticks(2);

    cur_req = "R5";
    mmask = 8'h10; irq[4] = 1; irq[3] = 1; ticks(2); ack = 1; tick(); ticks(2);
    mmask = 0; ticks(2); ack = 1; tick(); eoi[0] = 1; tick(); eoi[0] = 1; tick();
    irq[4] = 0; irq[3] = 0; ticks(2);

    cur_req = "R13";                      // collisions at one edge
    irq[3] = 1; ticks(2); ack = 1; tick(); eoi[0] = 1; tick();
    irq[3] = 0; tick(); irq[3] = 1; ticks(1);
    ack = 1; irq[3] = 0; tick(); irq[3] = 1; eoi[0] = 1; ack = 1; tick(); ticks(3);
    eoi = 2'b11; tick(); eoi = 2'b11; tick(); irq = '0; ticks(3);

    cur_req = "R5";                       // random soak
    for (int seg = 0; seg < 30; seg++) begin
      aeoi   = 2'($urandom);
      roten  = 2'($urandom);
      nested = 1'($urandom);
      mmask  = 8'($urandom) & 8'($urandom);
      smask  = 8'($urandom) & 8'($urandom);
      mbase  = 5'($urandom);
      sbase  = 5'($urandom);
      for (int k = 0; k < 120; k++) begin
        for (int b = 0; b < 16; b++) if ($urandom_range(0, 9) == 0) irq[b] = ~irq[b];
        ack = ($urandom_range(0, 3) == 0);
        eoi = {1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 4) == 0)};
        if ($urandom_range(0, 49) == 0) begin
          we = 2'($urandom_range(1, 3));
          wdata = 8'($urandom);
        end
        tick();
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule